// File: doc/BRIEF.md
# Resource-Limited Rename Slot Allocator

This block sits in the rename stage of an out-of-order core. Each cycle it looks at a window of decoded instructions, oldest at slot 0, and decides how many of them leave rename in program order. It never builds the register mapping. It only gates and orders acceptance.

Several limits bound the group:
- free space in the reorder buffer, the issue queue and the load/store queue;
- the rename width;
- the pool of free physical registers;
- the serialization flags that each instruction carries.

The block reports three things:
- how many entries were taken from the window (`consume_cnt`);
- how many of those go forward to dispatch (`accept_cnt`);
- whether decode must hold, with a code naming the limiting resource.

A serialize-before instruction puts the block in a serialize stall. The stall lasts until the back end reports that it has drained.

Top module: `rename_slot_alloc`

## Requirements
- R1: The queue budget is the least of `rob_free`, `iq_free` and `lsq_free`. On a tie, the reason reported is the reorder buffer first, then the issue queue, then the load/store queue. Reason codes: 0 none, 1 reorder buffer, 2 issue queue, 3 load/store queue, 4 physical registers, 5 serialize, 6 width.
- R2: When `n_wait` is non-zero and the budget is zero or negative, nothing is consumed, `stall_req` is 1 and the reason is the limiting queue.
- R3: When the budget is below `n_wait`, at most budget entries are consumed. If the group ends on that cap, `stall_req` is 1 and the reason is the limiting queue, unless R6 or R8 stopped the group first.
- R4: `accept_cnt` never exceeds WIDTH. If the group ends because WIDTH slots are used while entries remain, the reason is 6.
- R5: A squashed entry (`ins_squashed` bit set) is consumed and counts against the queue budget, but takes no output slot.
- R6: Serialize-before behaviour:
  - An unhandled serialize-before entry stops the group and is not consumed. `stall_req` is 1 and the reason is 5.
  - From the next cycle `ser_stall` is 1. While it is 1, nothing is consumed and the reason is 5.
  - In the cycle after `drain_done` is seen during the stall, `ser_stall` is 0 and the head entry counts as handled.
  - The head stays handled until something is consumed.
- R7: A serialize-after entry is accepted and marks the next live (non-squashed) entry as serialize-before. If no entry follows in the group, the mark passes to the window head of the next cycle.
- R8: Physical registers, with entry i's destination count at `ins_ndst[2i+1:2i]`:
  - An entry whose destination count exceeds the free registers remaining stops the group and is not consumed. `stall_req` is 1 and the reason is 4.
  - Each accepted entry takes its destinations away from the count seen by later entries in the same group.
- R9: When every waiting entry is consumed, `stall_req` is 0 and the reason is 0. When `n_wait` is 0, nothing happens and there is no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rob_free | input | CNT_W (signed) | Free reorder buffer entries |
| iq_free | input | CNT_W (signed) | Free issue queue entries |
| lsq_free | input | CNT_W (signed) | Free load/store queue entries |
| preg_free | input | PREG_W | Free physical registers |
| n_wait | input | WIN_W | Valid entries in the window |
| ins_squashed | input | WINDOW | Per-entry squashed flag |
| ins_ser_before | input | WINDOW | Per-entry serialize-before flag |
| ins_ser_after | input | WINDOW | Per-entry serialize-after flag |
| ins_ndst | input | WINDOW*DST_W | Per-entry destination register count |
| drain_done | input | 1 | Back end empty; releases a serialize stall |
| accept_cnt | output | SLOT_W | Entries forwarded this cycle |
| consume_cnt | output | WIN_W | Entries removed from the window this cycle |
| stall_req | output | 1 | Ask decode to hold |
| stall_why | output | 3 | Reason code |
| ser_stall | output | 1 | Serialize stall in force |

## Verification
The main allocation is driven with each queue in turn the smallest, and with two-way and three-way ties. This tells the tie-break order apart from a plain minimum.

Other patterns separate the remaining stop causes:
- A long window against the width cap separates a width stop from a queue stop.
- Squashed entries placed inside and at the edge of the budget show that they cost budget but no slot.
- A destination mix that fits one at a time but not together shows the per-group register decrement.
- Serialize sequences check entry and release of the stall, a handled head surviving a register stall, and a serialize-after mark carried across a squashed entry and across a cycle boundary.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

    typedef enum logic [2:0] {
        WHY_NONE   = 3'd0,
        WHY_ROB    = 3'd1,
        WHY_IQ     = 3'd2,
        WHY_LSQ    = 3'd3,
        WHY_PREG   = 3'd4,
        WHY_SERIAL = 3'd5,
        WHY_WIDTH  = 3'd6
    } why_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SSTALL = 1'b1
    } sstate_e;

    typedef struct packed {
        logic stop_ser;
        logic stop_preg;
        logic pend;
    } scan_flags_t;

endpackage

// File: rtl/rsa_budget.sv
module rsa_budget
    import rsa_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic signed [CNT_W-1:0] rob_free,
    input  logic signed [CNT_W-1:0] iq_free,
    input  logic signed [CNT_W-1:0] lsq_free,
    output logic signed [CNT_W-1:0] min_free,
    output why_e                    min_src
);
    // strict less-than keeps the earlier source on a tie
    always_comb begin
        min_free = rob_free;
        min_src  = WHY_ROB;
        if (iq_free < min_free) begin
            min_free = iq_free;
            min_src  = WHY_IQ;
        end
        if (lsq_free < min_free) begin
            min_free = lsq_free;
            min_src  = WHY_LSQ;
        end
    end
endmodule

// File: rtl/rsa_scan.sv
module rsa_scan
    import rsa_pkg::*;
#(
    parameter int WINDOW = 8,
    parameter int WIDTH  = 4,
    parameter int DST_W  = 2,
    parameter int PREG_W = 7,
    localparam int WIN_W  = $clog2(WINDOW + 1),
    localparam int SLOT_W = $clog2(WIDTH + 1)
) (
    input  logic                    enable,
    input  logic [WIN_W-1:0]        cap,
    input  logic [WINDOW-1:0]       sq,
    input  logic [WINDOW-1:0]       sb,
    input  logic [WINDOW-1:0]       sa,
    input  logic [WINDOW*DST_W-1:0] ndst,
    input  logic [PREG_W-1:0]       preg_free,
    input  logic                    carry_in,
    input  logic                    head_handled,
    output logic [SLOT_W-1:0]       slots,
    output logic [WIN_W-1:0]        consume,
    output scan_flags_t             flags
);
    logic [PREG_W-1:0] left;
    logic [PREG_W-1:0] need;
    logic              halt;

    always_comb begin
        slots = '0;
        consume = '0;
        flags = '{stop_ser: 1'b0, stop_preg: 1'b0, pend: carry_in};
        left = preg_free;
        need = '0;
        halt = 1'b0;
        for (int i = 0; i < WINDOW; i++) begin
            if (enable && !halt && consume < cap && slots < SLOT_W'(WIDTH)) begin
                if (sq[i]) begin
                    consume = consume + WIN_W'(1);
                end else begin
                    need = PREG_W'(ndst[i*DST_W +: DST_W]);
                    if ((sb[i] || flags.pend) && !(i == 0 && head_handled)) begin
                        halt = 1'b1;
                        flags.stop_ser = 1'b1;
                    end else if (left < need) begin
                        halt = 1'b1;
                        flags.stop_preg = 1'b1;
                    end else begin
                        slots = slots + SLOT_W'(1);
                        consume = consume + WIN_W'(1);
                        left = left - need;
                        flags.pend = sa[i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rsa_serctl.sv
module rsa_serctl
    import rsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_ser,
    input  logic drain_done,
    input  logic consumed_any,
    input  logic pend_out,
    output logic ser_stall,
    output logic carry_q,
    output logic handled_q
);
    sstate_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_RUN;
            carry_q   <= 1'b0;
            handled_q <= 1'b0;
        end else if (state_q == ST_SSTALL) begin
            if (drain_done) begin
                state_q   <= ST_RUN;
                handled_q <= 1'b1;
            end
        end else if (stop_ser) begin
            state_q   <= ST_SSTALL;
            carry_q   <= 1'b0;
            handled_q <= 1'b0;
        end else begin
            carry_q   <= pend_out;
            handled_q <= handled_q && !consumed_any;
        end
    end

    assign ser_stall = (state_q == ST_SSTALL);

    AST_SER_ENTER: assert property (@(posedge clk) disable iff (rst)
        (stop_ser && !ser_stall) |=> ser_stall);                         // R6
    AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ser_stall && !drain_done) |=> ser_stall);                       // R6
    AST_SER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ser_stall && drain_done) |=> (!ser_stall && handled_q));        // R6
endmodule

// File: rtl/rename_slot_alloc.sv
module rename_slot_alloc
    import rsa_pkg::*;
#(
    parameter int WINDOW = 8,
    parameter int WIDTH  = 4,
    parameter int CNT_W  = 6,
    parameter int PREG_W = 7,
    parameter int DST_W  = 2,
    localparam int WIN_W  = $clog2(WINDOW + 1),
    localparam int SLOT_W = $clog2(WIDTH + 1),
    localparam int MW     = (CNT_W > WIN_W) ? CNT_W : WIN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [CNT_W-1:0] rob_free,
    input  logic signed [CNT_W-1:0] iq_free,
    input  logic signed [CNT_W-1:0] lsq_free,
    input  logic [PREG_W-1:0]       preg_free,
    input  logic [WIN_W-1:0]        n_wait,
    input  logic [WINDOW-1:0]       ins_squashed,
    input  logic [WINDOW-1:0]       ins_ser_before,
    input  logic [WINDOW-1:0]       ins_ser_after,
    input  logic [WINDOW*DST_W-1:0] ins_ndst,
    input  logic                    drain_done,
    output logic [SLOT_W-1:0]       accept_cnt,
    output logic [WIN_W-1:0]        consume_cnt,
    output logic                    stall_req,
    output logic [2:0]              stall_why,
    output logic                    ser_stall
);
    logic signed [CNT_W-1:0] min_free;
    why_e                    min_src;
    logic                    blocked;
    logic                    capped;
    logic [MW-1:0]           mf_ext;
    logic [WIN_W-1:0]        cap;
    logic                    scan_en;
    logic                    carry_q;
    logic                    handled_q;
    scan_flags_t             sflags;
    why_e                    why;

    rsa_budget #(.CNT_W(CNT_W)) budget_i (
        .rob_free (rob_free),
        .iq_free  (iq_free),
        .lsq_free (lsq_free),
        .min_free (min_free),
        .min_src  (min_src)
    );

    assign blocked = (min_free <= 0);
    assign mf_ext  = MW'($unsigned(min_free));
    assign capped  = !blocked && (mf_ext < MW'(n_wait));
    assign cap     = blocked ? '0 : (capped ? WIN_W'(mf_ext) : n_wait);
    assign scan_en = !ser_stall && (n_wait != '0) && !blocked;

    rsa_scan #(
        .WINDOW (WINDOW),
        .WIDTH  (WIDTH),
        .DST_W  (DST_W),
        .PREG_W (PREG_W)
    ) scan_i (
        .enable       (scan_en),
        .cap          (cap),
        .sq           (ins_squashed),
        .sb           (ins_ser_before),
        .sa           (ins_ser_after),
        .ndst         (ins_ndst),
        .preg_free    (preg_free),
        .carry_in     (carry_q),
        .head_handled (handled_q),
        .slots        (accept_cnt),
        .consume      (consume_cnt),
        .flags        (sflags)
    );

    rsa_serctl serctl_i (
        .clk          (clk),
        .rst          (rst),
        .stop_ser     (sflags.stop_ser),
        .drain_done   (drain_done),
        .consumed_any (consume_cnt != '0),
        .pend_out     (sflags.pend),
        .ser_stall    (ser_stall),
        .carry_q      (carry_q),
        .handled_q    (handled_q)
    );

    // reason priority: stall state, empty window, queue block, group stop cause
    always_comb begin
        why = WHY_NONE;
        stall_req = 1'b0;
        if (ser_stall) begin
            why = WHY_SERIAL;
            stall_req = 1'b1;
        end else if (n_wait == '0) begin
            why = WHY_NONE;
        end else if (blocked) begin
            why = min_src;
            stall_req = 1'b1;
        end else if (sflags.stop_ser) begin
            why = WHY_SERIAL;
            stall_req = 1'b1;
        end else if (sflags.stop_preg) begin
            why = WHY_PREG;
            stall_req = 1'b1;
        end else if (consume_cnt < n_wait) begin
            stall_req = 1'b1;
            why = (capped && consume_cnt == cap) ? min_src : WHY_WIDTH;
        end
    end

    assign stall_why = why;

    AST_ACCEPT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (accept_cnt <= SLOT_W'(WIDTH)) && (WIN_W'(accept_cnt) <= consume_cnt)); // R4
    AST_CONSUME_BOUND: assert property (@(posedge clk) disable iff (rst)
        consume_cnt <= n_wait);                                                 // R3
    AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (n_wait != '0 && min_free <= 0) |-> (consume_cnt == '0 && stall_req));  // R2
    AST_SSTALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ser_stall |-> (consume_cnt == '0 && stall_req && stall_why == 3'd5));   // R6
    AST_LEFTOVER_STALL: assert property (@(posedge clk) disable iff (rst)
        (consume_cnt < n_wait) |-> stall_req);                                  // R9
endmodule

// File: tb/rename_slot_alloc_tb_top.sv
`timescale 1ns/1ps
module rename_slot_alloc_tb_top;
    localparam int WINDOW = 8;
    localparam int WIDTH  = 4;
    localparam int CNT_W  = 6;
    localparam int PREG_W = 7;
    localparam int DST_W  = 2;
    localparam int WIN_W  = $clog2(WINDOW + 1);
    localparam int SLOT_W = $clog2(WIDTH + 1);

    typedef struct {
        int    acc;
        int    cons;
        int    stall;
        int    why;
        int    ss;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [CNT_W-1:0] rob_free = '0, iq_free = '0, lsq_free = '0;
    logic [PREG_W-1:0] preg_free = '0;
    logic [WIN_W-1:0] n_wait = '0;
    logic [WINDOW-1:0] ins_squashed = '0, ins_ser_before = '0, ins_ser_after = '0;
    logic [WINDOW*DST_W-1:0] ins_ndst = '0;
    logic drain_done = 1'b0;
    logic [SLOT_W-1:0] accept_cnt;
    logic [WIN_W-1:0] consume_cnt;
    logic stall_req;
    logic [2:0] stall_why;
    logic ser_stall;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    rename_slot_alloc #(
        .WINDOW(WINDOW), .WIDTH(WIDTH), .CNT_W(CNT_W), .PREG_W(PREG_W), .DST_W(DST_W)
    ) dut_i (
        .clk(clk), .rst(rst),
        .rob_free(rob_free), .iq_free(iq_free), .lsq_free(lsq_free),
        .preg_free(preg_free), .n_wait(n_wait),
        .ins_squashed(ins_squashed), .ins_ser_before(ins_ser_before),
        .ins_ser_after(ins_ser_after), .ins_ndst(ins_ndst),
        .drain_done(drain_done),
        .accept_cnt(accept_cnt), .consume_cnt(consume_cnt),
        .stall_req(stall_req), .stall_why(stall_why), .ser_stall(ser_stall)
    );

    // driver: one call applies one cycle of inputs and queues its expectation
    task automatic go(input int rob, input int iq, input int lsq, input int preg,
                      input int nw, input logic [7:0] sq, input logic [7:0] sb,
                      input logic [7:0] sa, input logic [15:0] nd, input bit dr,
                      input int e_acc, input int e_cons, input int e_stall,
                      input int e_why, input int e_ss, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        rob_free = CNT_W'(rob);
        iq_free = CNT_W'(iq);
        lsq_free = CNT_W'(lsq);
        preg_free = PREG_W'(preg);
        n_wait = WIN_W'(nw);
        ins_squashed = sq;
        ins_ser_before = sb;
        ins_ser_after = sa;
        ins_ndst = nd;
        drain_done = dr;
        e = '{acc: e_acc, cons: e_cons, stall: e_stall, why: e_why, ss: e_ss, tag: tag};
        exp_q.push_back(e);
    endtask

    // monitor: compares at the falling edge, after inputs settle
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (int'(accept_cnt) != e.acc || int'(consume_cnt) != e.cons ||
                int'(stall_req) != e.stall || int'(stall_why) != e.why ||
                int'(ser_stall) != e.ss) begin
                errors++;
                $display("FAIL %s: got acc=%0d cons=%0d stall=%0d why=%0d ss=%0d, expected acc=%0d cons=%0d stall=%0d why=%0d ss=%0d",
                         e.tag, accept_cnt, consume_cnt, stall_req, stall_why, ser_stall,
                         e.acc, e.cons, e.stall, e.why, e.ss);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [15:0] ND1 = 16'h5555;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        go(10,10,10,20, 0, 8'h0,8'h0,8'h0, ND1,0, 0,0,0,0,0, "reset state R9");
        go(10,10,10,20, 3, 8'h0,8'h0,8'h0, ND1,0, 3,3,0,0,0, "R9 all consumed");
        go( 5, 2, 7,20, 4, 8'h0,8'h0,8'h0, ND1,0, 2,2,1,2,0, "R1 R3 iq cap");
        go( 2, 2, 2,20, 4, 8'h0,8'h0,8'h0, ND1,0, 2,2,1,1,0, "R1 three-way tie rob");
        go( 3, 1, 1,20, 4, 8'h0,8'h0,8'h0, ND1,0, 1,1,1,2,0, "R1 iq-lsq tie");
        go( 3, 3, 1,20, 4, 8'h0,8'h0,8'h0, ND1,0, 1,1,1,3,0, "R1 lsq smallest");
        go( 0, 5, 5,20, 2, 8'h0,8'h0,8'h0, ND1,0, 0,0,1,1,0, "R2 rob zero");
        go( 4,-1, 5,20, 2, 8'h0,8'h0,8'h0, ND1,0, 0,0,1,2,0, "R2 iq negative");
        go(10,10,10,20, 6, 8'h0,8'h0,8'h0, ND1,0, 4,4,1,6,0, "R4 width limit");
        go(10,10,10,20, 6, 8'h05,8'h0,8'h0, ND1,0, 4,6,0,0,0, "R5 squash no slot");
        go( 2,10,10,20, 4, 8'h01,8'h0,8'h0, ND1,0, 1,2,1,1,0, "R5 squash uses budget");
        go(10,10,10, 2, 3, 8'h0,8'h0,8'h0, 16'h0009,0, 1,1,1,4,0, "R8 per-group decrement");
        go(10,10,10, 0, 3, 8'h0,8'h0,8'h0, 16'h0000,0, 3,3,0,0,0, "R8 no dests need none");
        go(10,10,10,20, 4, 8'h0,8'h0,8'h02, ND1,0, 2,2,1,5,0, "R7 ser-after marks next");
        go(10,10,10,20, 2, 8'h0,8'h0,8'h0, ND1,0, 0,0,1,5,1, "R6 stall holds");
        go(10,10,10,20, 2, 8'h0,8'h0,8'h0, ND1,1, 0,0,1,5,1, "R6 release cycle");
        go(10,10,10,20, 2, 8'h0,8'h01,8'h0, ND1,0, 2,2,0,0,0, "R6 head handled");
        go(10,10,10,20, 4, 8'h0,8'h04,8'h0, ND1,0, 2,2,1,5,0, "R6 ser-before mid group");
        go(10,10,10,20, 4, 8'h0,8'h0,8'h0, ND1,1, 0,0,1,5,1, "R6 stall then drain");
        go(10,10,10, 0, 2, 8'h0,8'h01,8'h0, 16'h0001,0, 0,0,1,4,0, "R8 preg stop on handled head");
        go(10,10,10, 5, 2, 8'h0,8'h01,8'h0, ND1,0, 2,2,0,0,0, "R6 handled kept across preg stall");
        go(10,10,10,20, 2, 8'h0,8'h01,8'h0, ND1,0, 0,0,1,5,0, "R6 handled cleared");
        go(10,10,10,20, 2, 8'h0,8'h0,8'h0, ND1,1, 0,0,1,5,1, "R6 stall drain");
        go(10,10,10,20, 1, 8'h0,8'h01,8'h0, ND1,0, 1,1,0,0,0, "R6 release accept");
        go(10,10,10,20, 2, 8'h0,8'h0,8'h02, ND1,0, 2,2,0,0,0, "R7 ser-after last in group");
        go(10,10,10,20, 2, 8'h0,8'h0,8'h0, ND1,0, 0,0,1,5,0, "R7 mark carried to next head");
        go(10,10,10,20, 2, 8'h0,8'h0,8'h0, ND1,1, 0,0,1,5,1, "R7 stall drain");
        go(10,10,10,20, 1, 8'h0,8'h0,8'h0, ND1,0, 1,1,0,0,0, "R7 head after drain");
        go(10,10,10,20, 3, 8'h02,8'h0,8'h01, ND1,0, 1,2,1,5,0, "R7 mark skips squashed");
        go(10,10,10,20, 2, 8'h0,8'h0,8'h0, ND1,1, 0,0,1,5,1, "R7 stall drain 2");
        go(10,10,10,20, 0, 8'h0,8'h0,8'h0, ND1,0, 0,0,0,0,0, "R9 empty window");
        @(negedge clk);
        #1;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule